// File: doc/BRIEF.md
# Serial Bus Collision Detector

This block sits beside a serial transmitter and checks that what the transmitter drives onto the line is what comes back on the receive line. On every rising edge of the transmit shift clock inside the part of a frame that carries bits, it compares the transmit level with the receive level. A mismatch raises an interrupt request. The shift clock may come from the internal baud logic or from an external pin. In clock-synchronous mode the comparison covers the data bits only. In asynchronous (UART) mode it covers the start bit, the data bits and the stop bit.

The collision source shares one request bit and one enable bit with a key-on wakeup source. A valid bit decides whether collisions may raise requests. It must be cleared for half-duplex links, where the receive line does not follow the transmit line. A discrimination bit tells software which of the two sources raised the pending request.

The receive line and the selected shift clock are asynchronous to the system clock, so they pass through a synchronizer that is `SYNC_STAGES` deep. The transmit level and the frame-active window go through the same delay, so that all four samples stay aligned in time.

Top module: `sbus_collide_det`

## Requirements
- R1: After reset, all four registers read 0x00 and `irq_o` is low.
- R2: With the valid bit set, on each synchronized rising edge of the shift clock while `frame_active_i` is high and inside the window, a difference between the transmit and receive levels sets the request bit (address 2, bit 6). The request bit is visible `SYNC_STAGES`+1 clocks after the edge reaches the pins. Matching levels set nothing.
- R3: In clock-synchronous mode (`uart_mode_i`=0), only the first `DATA_BITS` rising edges of a frame are compared. Later edges are ignored.
- R4: In UART mode (`uart_mode_i`=1), the first `DATA_BITS`+2 rising edges of a frame are compared (start bit, data bits, stop bit). Later edges are ignored.
- R5: `sck_ext_sel_i`=0 selects `int_sck_i` as the shift clock and `sck_ext_sel_i`=1 selects `ext_sck_i`. Edges on the unselected clock have no effect.
- R6: The valid bit is address 0, bit 1. While it is 0, no collision sets the request bit.
- R7: A one-clock pulse on `keyon_i` sets the same request bit, whatever the valid bit holds.
- R8: The discrimination bit is address 1, bit 1, and is read-only. When the request bit goes from 0 to 1, it takes the value 1 if a collision caused the change and 0 if only key-on caused it. It keeps that value while the request bit stays set.
- R9: The request bit stays set until software writes address 2 with bit 6 = 0. Writing bit 6 = 1 has no effect. An event in the same clock as a clearing write leaves the bit set.
- R10: The enable bit is address 3, bit 6. `irq_o` is high exactly while the request bit and the enable bit are both 1.
- R11: All bits other than those named in R6, R8, R9 and R10 read as 0 and ignore writes.
- R12: Shift-clock edges while `frame_active_i` is low are never compared. The edge count restarts from zero at every new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txd_i | input | 1 | Level driven on the transmit line |
| rxd_i | input | 1 | Level seen on the receive line |
| int_sck_i | input | 1 | Shift clock from the internal generator |
| ext_sck_i | input | 1 | Shift clock from the external pin |
| sck_ext_sel_i | input | 1 | 1 selects the external shift clock |
| uart_mode_i | input | 1 | 1 selects UART framing, 0 clock-synchronous |
| frame_active_i | input | 1 | High while the transmitter sends a frame |
| keyon_i | input | 1 | Key-on wakeup event pulse |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i` |
| irq_o | output | 1 | Shared request to the interrupt controller |

## Verification
The bench builds the block with `DATA_BITS`=4 and `SYNC_STAGES`=3. The short data field lets each frame run past both the synchronous window and the UART window within a few dozen clocks, so mismatches on the last edge inside a window and on the first edge beyond it can both be placed. The three-stage synchronizer makes the request latency differ from the common two-stage case, which exposes any path that skips or adds a stage.

// File: rtl/sbcd_pkg.sv
package sbcd_pkg;

  localparam int unsigned REG_W     = 8;
  localparam int unsigned VALID_POS = 1;   // address 0
  localparam int unsigned ORIGIN_POS = 1;  // address 1
  localparam int unsigned REQ_POS   = 6;   // address 2
  localparam int unsigned EN_POS    = 6;   // address 3

  typedef enum logic [1:0] {
    A_SRCSET = 2'd0,
    A_ORIGIN = 2'd1,
    A_REQ    = 2'd2,
    A_EN     = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic tx;
    logic rx;
    logic sck;
    logic fa;
  } line_t;

  // number of compared shift-clock edges per frame
  function automatic int unsigned frame_window(logic uart, int unsigned data_bits);
    return uart ? data_bits + 2 : data_bits;
  endfunction

  // a register word holding one bit at a given position
  function automatic logic [REG_W-1:0] place_bit(logic v, int unsigned pos);
    logic [REG_W-1:0] r;
    r = '0;
    r[pos] = v;
    return r;
  endfunction

endpackage

// File: rtl/sbcd_sync.sv
module sbcd_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[g] <= '0;
          else        stg[g] <= stg[g-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sbcd_window.sv
module sbcd_window
  import sbcd_pkg::*;
#(
  parameter int unsigned DATA_BITS = 8
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  uart_mode,
  input  logic  valid,
  input  line_t ln,
  output logic  sck_rise,
  output logic  in_window,
  output logic  collide
);
  localparam int unsigned MAX_WIN = DATA_BITS + 2;
  localparam int unsigned CNT_W   = $clog2(MAX_WIN + 1) + 1;

  logic             sck_q;
  logic [CNT_W-1:0] edge_cnt;
  logic [CNT_W-1:0] win_len;

  assign win_len   = CNT_W'(frame_window(uart_mode, DATA_BITS));
  assign sck_rise  = ln.sck & ~sck_q;
  assign in_window = ln.fa & (edge_cnt < win_len);
  assign collide   = valid & sck_rise & in_window & (ln.tx ^ ln.rx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q    <= 1'b0;
      edge_cnt <= '0;
    end else begin
      sck_q <= ln.sck;
      if (!ln.fa)
        edge_cnt <= '0;
      else if (sck_rise && edge_cnt != {CNT_W{1'b1}})
        edge_cnt <= edge_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sbcd_irq_regs.sv
module sbcd_irq_regs
  import sbcd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [REG_W-1:0] wdata,
  input  logic             coll_evt,
  input  logic             keyon_evt,
  output logic [REG_W-1:0] rdata,
  output logic             valid,
  output logic             req,
  output logic             en,
  output logic             origin,
  output logic             irq
);
  logic any_evt;
  logic clr_req;

  assign any_evt = coll_evt | keyon_evt;
  assign clr_req = wr_en && (addr == A_REQ) && !wdata[REQ_POS];
  assign irq     = req & en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      en     <= 1'b0;
      req    <= 1'b0;
      origin <= 1'b0;
    end else begin
      if (wr_en && addr == A_SRCSET) valid <= wdata[VALID_POS];
      if (wr_en && addr == A_EN)     en    <= wdata[EN_POS];
      if (any_evt)      req <= 1'b1;
      else if (clr_req) req <= 1'b0;
      if (!req && any_evt) origin <= coll_evt;
    end
  end

  always_comb begin
    case (addr)
      A_SRCSET: rdata = place_bit(valid,  VALID_POS);
      A_ORIGIN: rdata = place_bit(origin, ORIGIN_POS);
      A_REQ:    rdata = place_bit(req,    REQ_POS);
      default:  rdata = place_bit(en,     EN_POS);
    endcase
  end
endmodule

// File: rtl/sbus_collide_det.sv
module sbus_collide_det
  import sbcd_pkg::*;
#(
  parameter int unsigned DATA_BITS   = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       txd_i,
  input  logic       rxd_i,
  input  logic       int_sck_i,
  input  logic       ext_sck_i,
  input  logic       sck_ext_sel_i,
  input  logic       uart_mode_i,
  input  logic       frame_active_i,
  input  logic       keyon_i,
  input  logic       reg_wr_i,
  input  logic [1:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       irq_o
);
  localparam int unsigned LINE_W = $bits(line_t);

  line_t line_raw;
  line_t line_s;
  logic  sck_sel;
  logic  sck_rise;
  logic  in_window;
  logic  coll_evt;
  logic  valid_bit;
  logic  req_bit;
  logic  en_bit;
  logic  origin_bit;

  assign sck_sel  = sck_ext_sel_i ? ext_sck_i : int_sck_i;
  assign line_raw = '{tx: txd_i, rx: rxd_i, sck: sck_sel, fa: frame_active_i};

  sbcd_sync #(.W(LINE_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (line_raw),
    .q     (line_s)
  );

  sbcd_window #(.DATA_BITS(DATA_BITS)) u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .uart_mode (uart_mode_i),
    .valid     (valid_bit),
    .ln        (line_s),
    .sck_rise  (sck_rise),
    .in_window (in_window),
    .collide   (coll_evt)
  );

  sbcd_irq_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr_i),
    .addr      (reg_addr_i),
    .wdata     (reg_wdata_i),
    .coll_evt  (coll_evt),
    .keyon_evt (keyon_i),
    .rdata     (reg_rdata_o),
    .valid     (valid_bit),
    .req       (req_bit),
    .en        (en_bit),
    .origin    (origin_bit),
    .irq       (irq_o)
  );
endmodule

// File: rtl/sbus_collide_det_chk.sv
module sbus_collide_det_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr_i,
  input logic [1:0] reg_addr_i,
  input logic [7:0] reg_wdata_i,
  input logic [7:0] reg_rdata_o,
  input logic       irq_o,
  input logic       keyon_i,
  input logic       coll_evt,
  input logic       sck_rise,
  input logic       in_window,
  input logic       valid_bit,
  input logic       req_bit,
  input logic       en_bit,
  input logic       origin_bit
);
  assert_coll_sets_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    coll_evt |=> req_bit);

  assert_coll_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    coll_evt |-> (sck_rise && in_window));

  assert_coll_needs_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    coll_evt |-> valid_bit);

  assert_keyon_sets_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    keyon_i |=> req_bit);

  assert_origin_coll_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_bit && coll_evt) |=> origin_bit);

  assert_origin_keyon_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_bit && keyon_i && !coll_evt) |=> !origin_bit);

  assert_req_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_bit && !(reg_wr_i && reg_addr_i == 2'd2 && !reg_wdata_i[6])) |=> req_bit);

  assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (en_bit && req_bit));

  assert_unused_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i == 2'd0) |-> ((reg_rdata_o & 8'hFD) == 8'h00));
endmodule

bind sbus_collide_det sbus_collide_det_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .irq_o       (irq_o),
  .keyon_i     (keyon_i),
  .coll_evt    (coll_evt),
  .sck_rise    (sck_rise),
  .in_window   (in_window),
  .valid_bit   (valid_bit),
  .req_bit     (req_bit),
  .en_bit      (en_bit),
  .origin_bit  (origin_bit)
);

// File: tb/sbus_collide_det_test.sv
module sbus_collide_det_test;
  localparam int DB = 4;
  localparam int SS = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic txd = 0, rxd = 0, isck = 0, esck = 0, esel = 0, uart = 0, fa = 0, keyon = 0;
  logic wr = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic irq;

  always #10 clk = ~clk;

  sbus_collide_det #(.DATA_BITS(DB), .SYNC_STAGES(SS)) uut (
    .clk(clk), .rst_n(rst_n), .txd_i(txd), .rxd_i(rxd), .int_sck_i(isck),
    .ext_sck_i(esck), .sck_ext_sel_i(esel), .uart_mode_i(uart),
    .frame_active_i(fa), .keyon_i(keyon), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done = 0;

  // ---------------- behavioural reference model ----------------
  typedef struct { bit tx; bit rx; bit sck; bit fa; } samp_t;
  samp_t hist[$];
  bit m_valid, m_en, m_req, m_org;
  int m_cnt;

  function automatic bit [7:0] m_read(bit [1:0] a);
    case (a)
      2'd0: return m_valid ? 8'h02 : 8'h00;
      2'd1: return m_org   ? 8'h02 : 8'h00;
      2'd2: return m_req   ? 8'h40 : 8'h00;
      default: return m_en ? 8'h40 : 8'h00;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    samp_t cur, prv, nw;
    bit rise, coll, ev;
    int win;
    if (!rst_n) begin
      m_valid = 0; m_en = 0; m_req = 0; m_org = 0; m_cnt = 0;
      hist = {};
      for (int i = 0; i <= SS; i++) hist.push_front('{0, 0, 0, 0});
    end else begin
      cur  = hist[SS-1];            // level seen SS edges ago
      prv  = hist[SS];
      rise = cur.sck && !prv.sck;
      win  = uart ? DB + 2 : DB;
      coll = m_valid && rise && cur.fa && (m_cnt < win) && (cur.tx != cur.rx);
      if (!cur.fa) m_cnt = 0;
      else if (rise) m_cnt = m_cnt + 1;
      ev = coll || keyon;
      if (!m_req && ev) m_org = coll;
      if (ev) m_req = 1;
      else if (wr && addr == 2'd2 && !wdata[6]) m_req = 0;
      if (wr && addr == 2'd0) m_valid = wdata[1];
      if (wr && addr == 2'd3) m_en = wdata[6];
      nw.tx = txd; nw.rx = rxd; nw.sck = esel ? esck : isck; nw.fa = fa;
      hist.push_front(nw);
      void'(hist.pop_back());
    end
  end

  // every-clock comparison against the model (R2, R10 on all traffic)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_tests++;
      if (irq !== (m_req && m_en)) begin
        n_fail++;
        $display("FAIL R10 model irq: actual %b expected %b at %0t", irq, m_req && m_en, $time);
      end
      n_tests++;
      if (rdata !== m_read(addr)) begin
        n_fail++;
        $display("FAIL R2 model rdata[%0d]: actual %h expected %h at %0t", addr, rdata, m_read(addr), $time);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(int n = 1);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic check_reg(bit [1:0] a, bit [7:0] exp, string tag);
    addr = a;
    @(negedge clk);
    n_tests++;
    if (rdata !== exp) begin
      n_fail++;
      $display("FAIL %s reg[%0d]: actual %h expected %h", tag, a, rdata, exp);
    end
    step();
  endtask

  task automatic check_irq(bit exp, string tag);
    @(negedge clk);
    n_tests++;
    if (irq !== exp) begin
      n_fail++;
      $display("FAIL %s irq: actual %b expected %b", tag, irq, exp);
    end
    step();
  endtask

  task automatic wreg(bit [1:0] a, bit [7:0] d);
    wr = 1; addr = a; wdata = d;
    step();
    wr = 0;
  endtask

  task automatic pulse_keyon();
    keyon = 1;
    step();
    keyon = 0;
  endtask

  // one frame of nbits shift-clock periods; bit 'bad' (1-based) mismatches
  task automatic frame(bit um, bit sel, bit drv_i, bit drv_e, int nbits, int bad, bit with_fa = 1);
    uart = um; esel = sel;
    step();
    fa = with_fa;
    for (int b = 1; b <= nbits; b++) begin
      isck = 0; esck = 0;
      txd = b[0];
      rxd = (b == bad) ? ~txd : txd;
      step(2);
      isck = drv_i; esck = drv_e;
      step(2);
    end
    isck = 0; esck = 0;
    step(2);
    fa = 0; rxd = txd;
    step(SS + 4);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin : watchdog
    #(20 * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  // ---------------- directed sequence ----------------
  initial begin
    step(3);
    rst_n = 1;
    step();
    // R1 reset state
    check_reg(0, 8'h00, "R1");
    check_reg(1, 8'h00, "R1");
    check_reg(2, 8'h00, "R1");
    check_reg(3, 8'h00, "R1");
    check_irq(0, "R1");

    // R11 writable bits only
    wreg(0, 8'hFF); check_reg(0, 8'h02, "R11");
    wreg(1, 8'hFF); check_reg(1, 8'h00, "R11");
    wreg(3, 8'hFF); check_reg(3, 8'h40, "R11");

    // R2 matching frame, then mismatching frame
    frame(0, 0, 1, 0, DB, 0);
    check_reg(2, 8'h00, "R2 match");
    frame(0, 0, 1, 0, DB, 2);
    check_reg(2, 8'h40, "R2 mismatch");
    check_reg(1, 8'h02, "R8 origin collision");
    check_irq(1, "R10");

    // R9 write 1 keeps, write 0 clears
    wreg(2, 8'hFF); check_reg(2, 8'h40, "R9 write1");
    wreg(2, 8'h00); check_reg(2, 8'h00, "R9 clear");

    // R3 synchronous window
    frame(0, 0, 1, 0, DB + 2, DB + 1);
    check_reg(2, 8'h00, "R3 past window");
    frame(0, 0, 1, 0, DB + 2, DB);
    check_reg(2, 8'h40, "R3 last bit");
    wreg(2, 8'h00);

    // R4 UART window
    frame(1, 0, 1, 0, DB + 3, DB + 2);
    check_reg(2, 8'h40, "R4 stop bit");
    wreg(2, 8'h00);
    frame(1, 0, 1, 0, DB + 3, DB + 3);
    check_reg(2, 8'h00, "R4 past stop");
    frame(1, 0, 1, 0, DB + 3, 1);
    check_reg(2, 8'h40, "R4 start bit");
    wreg(2, 8'h00);

    // R5 clock selection
    frame(0, 1, 0, 1, DB, 1);
    check_reg(2, 8'h40, "R5 external");
    wreg(2, 8'h00);
    frame(0, 1, 1, 0, DB, 1);
    check_reg(2, 8'h00, "R5 unselected");
    frame(0, 0, 0, 1, DB, 1);
    check_reg(2, 8'h00, "R5 unselected ext");

    // R6 valid cleared
    wreg(0, 8'h00);
    frame(0, 0, 1, 0, DB, 1);
    check_reg(2, 8'h00, "R6 invalid");
    wreg(0, 8'h02);

    // R12 edges outside frame_active
    frame(0, 0, 1, 0, DB, 1, 0);
    check_reg(2, 8'h00, "R12 no frame");

    // R7 key-on, R8 origin
    pulse_keyon();
    check_reg(2, 8'h40, "R7 keyon");
    check_reg(1, 8'h00, "R8 origin keyon");
    frame(0, 0, 1, 0, DB, 1);
    check_reg(1, 8'h00, "R8 origin kept");

    // R10 enable gating
    wreg(3, 8'h00); check_irq(0, "R10 disabled");
    check_reg(2, 8'h40, "R10 req kept");
    wreg(3, 8'h40); check_irq(1, "R10 enabled");

    // R9 clear in same clock as event
    wreg(2, 8'h00);
    keyon = 1; wr = 1; addr = 2; wdata = 8'h00;
    step();
    keyon = 0; wr = 0;
    check_reg(2, 8'h40, "R9 event wins");
    wreg(2, 8'h00);
    check_reg(2, 8'h00, "R9 final clear");

    step(4);
    finish_run();
  end
endmodule